// File: doc/BRIEF.md
# Masked Watchpoint Comparator Pair

This block watches a processor's bus every clock cycle: the address, the data and a small control vector that tells reads from writes, gives the access size, and marks instruction fetches and translated accesses. Two watchpoint units each hold a value and a mask for every one of these three fields. A unit matches when all bits that its masks leave in the comparison agree with its value registers. A unit whose data and control masks ignore everything except the fetch bit therefore behaves as a breakpoint on one code address.

A registered halt request goes high one cycle after a qualifying bus cycle. In normal mode a match on either unit is enough. In chained mode unit 1 only counts once unit 0 has matched in an earlier cycle. That earlier match is remembered in an armed flag. The flag is dropped by reset or by any write on the programming port. An external system-event input also raises the halt request. Once set, the request stays high until the debugger pulses a clear input.

Programming uses a single-cycle write port. Address bit 3 selects the unit and bits 2:0 select the field. Nothing can be read back; the only output is the halt request.

Top module: `watch_halt_top`

## Requirements
- R1: After synchronous reset `halt_req` is 0, every value and mask register is 0, both units are disabled and chained mode is off.
- R2: The address field is compared under its mask. An address mask bit of 1 drops that bit from the comparison. A mask bit of 0 requires `bus_addr` to equal the stored address value in that bit.
- R3: The data field is compared under its mask in the same way, against `bus_data`.
- R4: The control value register is CTRL_W+1 bits wide. Bits CTRL_W-1:0 hold the compare value and bit CTRL_W is the unit enable. The control mask is CTRL_W bits wide. The control bits are: bit 0 write, bits 2:1 access size, bit 3 instruction fetch, bit 4 translated access, and the rest spare.
- R5: A unit whose enable bit is 0 never matches, whatever is on the bus and whatever its masks hold.
- R6: In normal mode (mode bit 0 = 0), a bus cycle that matches either unit makes `halt_req` 1 in the next cycle.
- R7: In chained mode (mode bit 0 = 1), a unit 1 match raises the halt request only if unit 0 matched in a strictly earlier cycle since the armed flag was last cleared. Unit 0 and unit 1 matching in the same cycle does not raise it, but that cycle arms the flag.
- R8: Any write on the programming port clears the armed flag, and the write wins over a unit 0 match in the same cycle.
- R9: `sys_evt` high in a cycle makes `halt_req` 1 in the next cycle, in either mode.
- R10: `halt_req` stays 1 until `dbg_clr` is high in a cycle with no new halt condition. It is then 0 in the next cycle. A halt condition in the same cycle as `dbg_clr` keeps it at 1.
- R11: Register map: `cfg_addr[3]` selects the unit and `cfg_addr[2:0]` selects the field. The fields are 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value and 5 control mask. Address 7 is the mode register, with bit 0 as the chain bit. Fields 6 and 15 are ignored. Each register takes the low bits of `cfg_wdata`, and the comparisons use the new value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Observed address bus |
| bus_data | input | DATA_W | Observed data bus |
| bus_ctrl | input | CTRL_W | Observed control vector (layout in R4) |
| sys_evt | input | 1 | External halt event |
| dbg_clr | input | 1 | Clears the halt request |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select (R11) |
| cfg_wdata | input | WR_W | Register write data |
| halt_req | output | 1 | Registered, sticky halt request |

## Verification
Each field is tried in turn with a single unit enabled and the other two fields fully masked. In every case one bus value matches and a near value differs only in a compared bit, which separates masked bits from compared bits. The control test uses a fetch-only mask, so it shows whether the fetch bit is tested alone. Chained mode is tried with unit 1 alone, with both units in the same cycle, with unit 0 and then unit 1, and with a register write between them. These runs tell apart correct ordering, same-cycle arming, and the write clearing the armed flag. The external event and the clear are driven alone and together, which shows whether a clear drops the request and whether a new condition outranks the clear.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int NUM_UNITS = 2;

  typedef enum logic [2:0] {
    F_AVAL = 3'd0,
    F_AMSK = 3'd1,
    F_DVAL = 3'd2,
    F_DMSK = 3'd3,
    F_CVAL = 3'd4,
    F_CMSK = 3'd5,
    F_RSVD = 3'd6,
    F_MODE = 3'd7
  } field_e;
endpackage

// File: rtl/watch_regs.sv
module watch_regs
  import watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int WR_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_addr,
  input  logic [WR_W-1:0]               wr_data,
  output logic [NUM_UNITS*ADDR_W-1:0]   aval_o,
  output logic [NUM_UNITS*ADDR_W-1:0]   amsk_o,
  output logic [NUM_UNITS*DATA_W-1:0]   dval_o,
  output logic [NUM_UNITS*DATA_W-1:0]   dmsk_o,
  output logic [NUM_UNITS*CTRL_W-1:0]   cval_o,
  output logic [NUM_UNITS*CTRL_W-1:0]   cmsk_o,
  output logic [NUM_UNITS-1:0]          en_o,
  output logic                          chain_o
);
  localparam int CV_W = CTRL_W + 1;

  field_e fld;
  assign fld = field_e'(wr_addr[2:0]);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic UBIT = 1'(u);
    logic              sel;
    logic [ADDR_W-1:0] av_q, am_q;
    logic [DATA_W-1:0] dv_q, dm_q;
    logic [CV_W-1:0]   cv_q;
    logic [CTRL_W-1:0] cm_q;

    assign sel = wr_en && (wr_addr[3] == UBIT);

    always_ff @(posedge clk) begin
      if (rst) begin
        av_q <= '0;
        am_q <= '0;
        dv_q <= '0;
        dm_q <= '0;
        cv_q <= '0;
        cm_q <= '0;
      end else if (sel) begin
        case (fld)
          F_AVAL:  av_q <= wr_data[ADDR_W-1:0];
          F_AMSK:  am_q <= wr_data[ADDR_W-1:0];
          F_DVAL:  dv_q <= wr_data[DATA_W-1:0];
          F_DMSK:  dm_q <= wr_data[DATA_W-1:0];
          F_CVAL:  cv_q <= wr_data[CV_W-1:0];
          F_CMSK:  cm_q <= wr_data[CTRL_W-1:0];
          default: ;
        endcase
      end
    end

    assign aval_o[u*ADDR_W +: ADDR_W] = av_q;
    assign amsk_o[u*ADDR_W +: ADDR_W] = am_q;
    assign dval_o[u*DATA_W +: DATA_W] = dv_q;
    assign dmsk_o[u*DATA_W +: DATA_W] = dm_q;
    assign cval_o[u*CTRL_W +: CTRL_W] = cv_q[CTRL_W-1:0];
    assign cmsk_o[u*CTRL_W +: CTRL_W] = cm_q;
    assign en_o[u]                    = cv_q[CTRL_W];
  end

  logic chain_q;
  always_ff @(posedge clk) begin
    if (rst) chain_q <= 1'b0;
    else if (wr_en && wr_addr == {1'b0, F_MODE}) chain_q <= wr_data[0];
  end
  assign chain_o = chain_q;
endmodule

// File: rtl/watch_cmp.sv
module watch_cmp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CTRL_W-1:0] bus_ctrl,
  input  logic [ADDR_W-1:0] aval,
  input  logic [ADDR_W-1:0] amsk,
  input  logic [DATA_W-1:0] dval,
  input  logic [DATA_W-1:0] dmsk,
  input  logic [CTRL_W-1:0] cval,
  input  logic [CTRL_W-1:0] cmsk,
  input  logic              en,
  output logic              hit
);
  logic a_ok, d_ok, c_ok;

  always_comb begin
    a_ok = ((bus_addr ^ aval) & ~amsk) == '0;
    d_ok = ((bus_data ^ dval) & ~dmsk) == '0;
    c_ok = ((bus_ctrl ^ cval) & ~cmsk) == '0;
    hit  = en && a_ok && d_ok && c_ok;
  end
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
  import watch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_UNITS-1:0] hit,
  input  logic                 chain,
  input  logic                 sys_evt,
  input  logic                 dbg_clr,
  input  logic                 any_wr,
  output logic                 halt_o
);
  logic armed_q, halt_q, set_c;

  always_comb begin
    if (chain) set_c = sys_evt || (hit[1] && armed_q);
    else       set_c = sys_evt || (|hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      halt_q <= set_c || (halt_q && !dbg_clr);
      if (any_wr)      armed_q <= 1'b0;
      else if (hit[0]) armed_q <= 1'b1;
    end
  end

  assign halt_o = halt_q;

  p_evt_sets_halt_r9: assert property (@(posedge clk) disable iff (rst)
    sys_evt |=> halt_o);

  p_halt_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (halt_o && !dbg_clr) |=> halt_o);

  p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (dbg_clr && !sys_evt && hit == '0) |=> !halt_o);

  p_chain_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
    (chain && !armed_q && !sys_evt && !halt_o) |=> !halt_o);

  p_write_disarms_r8: assert property (@(posedge clk) disable iff (rst)
    any_wr |=> !armed_q);

  p_normal_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (!chain && hit != '0) |=> halt_o);
endmodule

// File: rtl/watch_halt_top.sv
module watch_halt_top
  import watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int WR_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CTRL_W-1:0] bus_ctrl,
  input  logic              sys_evt,
  input  logic              dbg_clr,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [WR_W-1:0]   cfg_wdata,
  output logic              halt_req
);
  logic [NUM_UNITS*ADDR_W-1:0] aval, amsk;
  logic [NUM_UNITS*DATA_W-1:0] dval, dmsk;
  logic [NUM_UNITS*CTRL_W-1:0] cval, cmsk;
  logic [NUM_UNITS-1:0]        en, hit;
  logic                        chain;

  watch_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .WR_W(WR_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .aval_o(aval), .amsk_o(amsk), .dval_o(dval),
    .dmsk_o(dmsk), .cval_o(cval), .cmsk_o(cmsk), .en_o(en), .chain_o(chain)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cmp
    watch_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) cmp_i (
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
      .aval(aval[u*ADDR_W +: ADDR_W]), .amsk(amsk[u*ADDR_W +: ADDR_W]),
      .dval(dval[u*DATA_W +: DATA_W]), .dmsk(dmsk[u*DATA_W +: DATA_W]),
      .cval(cval[u*CTRL_W +: CTRL_W]), .cmsk(cmsk[u*CTRL_W +: CTRL_W]),
      .en(en[u]), .hit(hit[u])
    );

    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      !en[u] |-> !hit[u]);
  end

  halt_ctrl ctrl_i (
    .clk(clk), .rst(rst), .hit(hit), .chain(chain), .sys_evt(sys_evt),
    .dbg_clr(dbg_clr), .any_wr(cfg_wr), .halt_o(halt_req)
  );

  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !halt_req);
endmodule

// File: tb/watch_halt_top_tb_top.sv
module watch_halt_top_tb_top;
  localparam int AW = 32, DW = 32, CW = 8, WW = 32;
  localparam logic [31:0] IDLE_A = 32'h5A5A_0000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = IDLE_A;
  logic [DW-1:0] bus_data = '0;
  logic [CW-1:0] bus_ctrl = '0;
  logic sys_evt = 1'b0, dbg_clr = 1'b0, cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [WW-1:0] cfg_wdata = '0;
  logic halt_req;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  watch_halt_top #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW), .WR_W(WW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ctrl(bus_ctrl), .sys_evt(sys_evt), .dbg_clr(dbg_clr),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .halt_req(halt_req)
  );

  // behavioural reference model
  logic [31:0] m_av[2], m_am[2], m_dv[2], m_dm[2];
  logic [8:0]  m_cv[2];
  logic [7:0]  m_cm[2];
  bit m_chain, m_arm, m_halt;

  function automatic bit unit_hit(int u);
    bit ok = m_cv[u][8];
    for (int b = 0; b < 32; b++) begin
      if (!m_am[u][b] && bus_addr[b] != m_av[u][b]) ok = 0;
      if (!m_dm[u][b] && bus_data[b] != m_dv[u][b]) ok = 0;
    end
    for (int b = 0; b < 8; b++)
      if (!m_cm[u][b] && bus_ctrl[b] != m_cv[u][b]) ok = 0;
    return ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < 2; u++) begin
        m_av[u] = 0; m_am[u] = 0; m_dv[u] = 0; m_dm[u] = 0;
        m_cv[u] = 0; m_cm[u] = 0;
      end
      m_chain = 0; m_arm = 0; m_halt = 0;
    end else begin
      bit h0, h1, trig;
      int u;
      h0 = unit_hit(0);
      h1 = unit_hit(1);
      trig = sys_evt || (m_chain ? (h1 && m_arm) : (h0 || h1));
      m_halt = trig || (m_halt && !dbg_clr);
      if (cfg_wr) m_arm = 0;
      else if (h0) m_arm = 1;
      if (cfg_wr) begin
        u = int'(cfg_addr[3]);
        case (cfg_addr[2:0])
          3'd0: m_av[u] = cfg_wdata;
          3'd1: m_am[u] = cfg_wdata;
          3'd2: m_dv[u] = cfg_wdata;
          3'd3: m_dm[u] = cfg_wdata;
          3'd4: m_cv[u] = cfg_wdata[8:0];
          3'd5: m_cm[u] = cfg_wdata[7:0];
          3'd7: if (u == 0) m_chain = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (halt_req !== m_halt) begin
        mismatched++;
        $display("FAIL model R6/R7/R9/R10 t=%0t halt_req actual=%0b expected=%0b",
                 $time, halt_req, m_halt);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(string req, bit exp);
    compared++;
    if (halt_req !== exp) begin
      mismatched++;
      $display("FAIL %s halt_req actual=%0b expected=%0b", req, halt_req, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic step(logic [31:0] a, logic [31:0] d, logic [7:0] c, bit ev, bit clr);
    bus_addr = a; bus_data = d; bus_ctrl = c; sys_evt = ev; dbg_clr = clr;
    @(posedge clk); @(negedge clk);
    sys_evt = 0; dbg_clr = 0;
  endtask

  task automatic quiet();
    wr(4'h4, 0); wr(4'hC, 0); wr(4'h7, 0);
    step(IDLE_A, 0, 0, 0, 1);
    chk("R5 quiet", 0);
  endtask

  task automatic setup(int u, logic [31:0] av, logic [31:0] am, logic [31:0] dv,
                       logic [31:0] dm, logic [8:0] cv, logic [7:0] cm);
    logic [3:0] b = u[0] ? 4'h8 : 4'h0;
    wr(b | 4'h0, av); wr(b | 4'h1, am); wr(b | 4'h2, dv);
    wr(b | 4'h3, dm); wr(b | 4'h5, {24'h0, cm}); wr(b | 4'h4, {23'h0, cv});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 halt during reset", 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", 0);
    step(32'h0, 32'h0, 8'h0, 0, 0);
    chk("R1 R5 zero bus, units disabled", 0);

    // address under mask: unit0
    setup(0, 32'h0000_1000, 32'h0000_000F, 0, ONES, 9'h100, 8'hFF);
    step(32'h0000_1004, 32'h1234, 8'h01, 0, 0);
    chk("R2 R6 masked address bit ignored", 1);
    step(32'h0000_1010, 0, 0, 0, 1);
    chk("R2 compared address bit differs", 0);

    // data under mask: unit1
    quiet();
    setup(1, 0, ONES, 32'hCAFE_0000, 32'h0000_FFFF, 9'h100, 8'hFF);
    step(IDLE_A, 32'hCAFE_1234, 0, 0, 0);
    chk("R3 R6 unit1 data match", 1);
    step(IDLE_A, 32'hCAFF_0000, 0, 0, 1);
    chk("R3 data compared bit differs", 0);

    // control: fetch-only breakpoint on unit0
    quiet();
    setup(0, 0, ONES, 0, ONES, 9'h108, 8'hF7);
    step(IDLE_A, 0, 8'h08, 0, 0);
    chk("R4 fetch bit matches", 1);
    step(IDLE_A, 0, 8'hF7, 0, 1);
    chk("R4 fetch bit clear", 0);

    // disabled with everything masked
    wr(4'h4, 32'h0000_0008);
    step(32'h1, 32'h2, 8'h08, 0, 0);
    chk("R5 disabled unit, all masked", 0);

    // chained mode
    quiet();
    setup(0, 32'h0000_2000, 0, 0, ONES, 9'h100, 8'hFF);
    setup(1, 0, ONES, 32'h77, 0, 9'h100, 8'hFF);
    wr(4'h7, 1);
    step(IDLE_A, 32'h77, 0, 0, 0);
    chk("R7 unit1 alone unarmed", 0);
    step(32'h2000, 32'h77, 0, 0, 0);
    chk("R7 same cycle no halt", 0);
    step(IDLE_A, 0, 0, 0, 0);
    chk("R7 idle after arm", 0);
    step(IDLE_A, 32'h77, 0, 0, 0);
    chk("R7 unit1 after unit0", 1);
    step(IDLE_A, 0, 0, 0, 1);
    chk("R10 clear in chain mode", 0);
    wr(4'h7, 1);
    step(IDLE_A, 32'h77, 0, 0, 0);
    chk("R8 write disarms", 0);
    step(32'h2000, 0, 0, 0, 0);
    step(IDLE_A, 32'h77, 0, 0, 0);
    chk("R7 rearm then fire", 1);
    wr(4'h6, 32'hFFFF_FFFF);
    wr(4'hF, 0);
    step(IDLE_A, 0, 0, 0, 1);
    chk("R11 reserved writes keep chain mode", 0);
    step(IDLE_A, 32'h77, 0, 0, 0);
    chk("R11 R8 disarmed by reserved write", 0);
    wr(4'h7, 0);
    step(IDLE_A, 32'h77, 0, 0, 1);
    chk("R6 R10 normal-mode hit wins over clear", 1);
    step(IDLE_A, 0, 0, 0, 1);
    chk("R10 clear", 0);

    // external event
    quiet();
    step(IDLE_A, 0, 0, 1, 0);
    chk("R9 external event", 1);
    step(IDLE_A, 0, 0, 0, 0);
    step(IDLE_A, 0, 0, 0, 0);
    chk("R10 halt holds", 1);
    step(IDLE_A, 0, 0, 1, 1);
    chk("R10 event with clear", 1);
    step(IDLE_A, 0, 0, 0, 1);
    chk("R10 clear drops", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule